// File: doc/BRIEF.md
# Snapshot Imager Frame Timing Generator

This block sits on the camera side of a snapshot-mode infrared readout chip and produces every timing signal that chip expects: a sensor clock, a frame sync, a line sync and a serial command line. It runs from a system clock at twice the sensor clock rate, so each output can be moved on the exact sensor clock edge the chip needs. Line sync and frame sync move with the sensor clock's falling edge. The serial command bit moves with its rising edge, so it is stable when the chip samples it on the falling edge.

A frame begins when the frame sync rises. That edge also makes the chip commit the command word shifted in during the previous frame, and the falling edge of frame sync starts integration. Two sequencing modes are offered. In sequential mode, frame sync stays high through the whole readout, and integration follows it. In overlapped mode, frame sync drops partway through the readout, so the next exposure runs alongside the current readout. The line count, clocks per line, integration time and mode are captured when a frame starts. A command word can be queued at any time and goes out during the next frame that starts.

The state machine has three states. ST_IDLE moves to ST_READ on an accepted start. ST_READ moves to ST_INTEG after the last readout clock in sequential mode. ST_READ moves to ST_IDLE after the last readout clock in overlapped mode. ST_INTEG moves to ST_IDLE after the last integration clock. From the final clock of ST_READ (overlapped mode) or ST_INTEG, an accepted start goes straight to ST_READ.

Top module: `snap_frame_timer`

## Requirements
- R1: The sensor clock toggles on every system clock edge. While reset is applied and just after it, frame sync, line sync, serial data and busy are all low.
- R2: A start request is sampled on falling edges of the sensor clock. When accepted, frame sync rises and busy is high on that same edge (frame tick 0).
- R3: Let L be the line count and P the clocks per line, with a zero in either treated as one, and let R = L×P. On frame ticks 1 to R, line sync is high exactly on the ticks where (tick−1) mod P is 0. There are therefore L pulses, each one sensor clock wide, and the first comes one full sensor clock after frame sync rises.
- R4: Sequential mode (mode input 1). Frame sync stays high on ticks 0 to R and is low from tick R+1. Let I be the integration time, with zero treated as one. Integration lasts I sensor clocks, and the frame occupies ticks 0 to R+I.
- R5: Overlapped mode (mode input 0). Frame sync is high on ticks below H and low from H onward, where H = R+1−min(I,R). The frame occupies ticks 0 to R, so the earliest next rise is tick R+1.
- R6: Busy is high on every tick of a frame and low on the tick after it. A start request sampled while busy is ignored, with no effect on the frame sync or line sync pattern. The one exception is the frame's final tick.
- R7: A start request sampled on a frame's final tick begins the next frame on the following tick, with no idle tick in between.
- R8: A command load pulse stores the command word as pending, and a later load replaces it. At the next accepted frame start, the pending word is sent most significant bit first. Its bit j (j=0 is the MSB) is on serial data during frame tick j+1, and serial data is low otherwise. A word loaded during a frame waits for the next frame.
- R9: Mode, line count, clocks per line and integration time are taken only at frame start. Changing them during a frame has no effect on that frame.
- R10: Frame sync and line sync change only on a falling edge of the sensor clock, and serial data changes only on a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the sensor clock rate |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Frame start request, sampled on sensor clock falling edges |
| seq_mode | input | 1 | 1 = sequential (integrate after readout), 0 = overlapped |
| int_clks | input | INT_W | Integration time in sensor clocks (0 acts as 1) |
| line_count | input | LINE_W | Rows per frame (0 acts as 1) |
| line_clks | input | CLKS_W | Sensor clocks per row (0 acts as 1) |
| cmd_word | input | CMD_W | Command word to queue |
| cmd_load | input | 1 | One-cycle pulse that queues cmd_word |
| sensor_clk | output | 1 | Sensor clock |
| frame_sync | output | 1 | Frame sync to the readout chip |
| line_sync | output | 1 | Line sync to the readout chip |
| ser_data | output | 1 | Serial command bit |
| busy | output | 1 | A frame is in progress |

## Verification
Ending one frame and starting the next can fall on the same sensor clock tick. The bench provokes this by raising start just before the final readout tick in overlapped mode, and just before the final integration tick in sequential mode. It then checks that frame sync is high on the very next tick and that the second frame's line sync pattern starts exactly one clock later. A command load is also made to coincide with a running frame. The bench checks that the running frame's serial bits are unaffected and that the new word appears, bit for bit, only in the following frame.

// File: rtl/snap_frame_pkg.sv
package snap_frame_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_INTEG = 2'd2
    } sft_state_e;
endpackage

// File: rtl/sft_tick_gen.sv
module sft_tick_gen (
    input  logic clk,
    input  logic rst,
    output logic sensor_clk,
    output logic fall_tick,
    output logic rise_tick
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign sensor_clk = phase_q;
    // the edge that ends a cycle with phase high lowers the sensor clock
    assign fall_tick  = phase_q;
    assign rise_tick  = ~phase_q;
endmodule

// File: rtl/sft_frame_fsm.sv
module sft_frame_fsm
    import snap_frame_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int CLKS_W = 10,
    parameter int INT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fall_tick,
    input  logic              start,
    input  logic              seq_mode,
    input  logic [INT_W-1:0]  int_clks,
    input  logic [LINE_W-1:0] line_count,
    input  logic [CLKS_W-1:0] line_clks,
    output logic              frame_sync,
    output logic              line_sync,
    output logic              busy,
    output logic              frame_go
);
    localparam int RW = LINE_W + CLKS_W;
    localparam int CW = ((RW > INT_W) ? RW : INT_W) + 1;

    sft_state_e st, st_nx;

    logic [RW-1:0]     kc;
    logic [CLKS_W-1:0] pos;
    logic [INT_W-1:0]  icnt;
    logic              c_seq;
    logic [CLKS_W-1:0] c_p;
    logic [INT_W-1:0]  c_i;
    logic [RW-1:0]     c_r;
    logic [RW-1:0]     c_h;

    logic [LINE_W-1:0] le;
    logic [CLKS_W-1:0] pe;
    logic [INT_W-1:0]  ie;
    logic [RW-1:0]     r_calc;
    logic [RW-1:0]     h_calc;
    logic [CW-1:0]     r_x;
    logic [CW-1:0]     i_x;
    logic              last_read;
    logic              last_int;
    logic              done;

    // effective settings for a frame about to start
    always_comb begin
        le     = (line_count == '0) ? LINE_W'(1) : line_count;
        pe     = (line_clks == '0)  ? CLKS_W'(1) : line_clks;
        ie     = (int_clks == '0)   ? INT_W'(1)  : int_clks;
        r_calc = RW'(le) * RW'(pe);
        r_x    = CW'(r_calc);
        i_x    = CW'(ie);
        h_calc = (i_x >= r_x) ? RW'(1) : RW'(r_x + CW'(1) - i_x);
    end

    assign last_read = (st == ST_READ)  && (kc == c_r);
    assign last_int  = (st == ST_INTEG) && (icnt == c_i);
    assign done      = (last_read && !c_seq) || last_int;
    assign frame_go  = fall_tick && start && ((st == ST_IDLE) || done);
    assign busy      = (st != ST_IDLE);

    // next-state decision
    always_comb begin
        st_nx = st;
        if (fall_tick) begin
            if (frame_go) begin
                st_nx = ST_READ;
            end else begin
                unique case (st)
                    ST_IDLE:  st_nx = ST_IDLE;
                    ST_READ:  if (last_read) st_nx = c_seq ? ST_INTEG : ST_IDLE;
                    ST_INTEG: if (last_int)  st_nx = ST_IDLE;
                    default:  st_nx = ST_IDLE;
                endcase
            end
        end
    end

    // state register, frame counters and captured settings
    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            kc    <= '0;
            pos   <= '0;
            icnt  <= '0;
            c_seq <= 1'b0;
            c_p   <= CLKS_W'(1);
            c_i   <= INT_W'(1);
            c_r   <= RW'(1);
            c_h   <= RW'(1);
        end else begin
            st <= st_nx;
            if (frame_go) begin
                kc    <= '0;
                pos   <= '0;
                icnt  <= '0;
                c_seq <= seq_mode;
                c_p   <= pe;
                c_i   <= ie;
                c_r   <= r_calc;
                c_h   <= h_calc;
            end else if (fall_tick) begin
                if (st == ST_READ && !last_read) begin
                    kc  <= kc + RW'(1);
                    pos <= (pos == c_p - CLKS_W'(1)) ? '0 : pos + CLKS_W'(1);
                end
                if (st == ST_READ && last_read) icnt <= INT_W'(1);
                if (st == ST_INTEG)             icnt <= icnt + INT_W'(1);
            end
        end
    end

    // sync outputs, updated only with the sensor clock falling edge
    always_ff @(posedge clk) begin
        if (rst) begin
            frame_sync <= 1'b0;
            line_sync  <= 1'b0;
        end else if (fall_tick) begin
            if (frame_go) begin
                frame_sync <= 1'b1;
                line_sync  <= 1'b0;
            end else if (st == ST_READ && !last_read) begin
                line_sync  <= (pos == '0);
                frame_sync <= c_seq ? 1'b1 : ((kc + RW'(1)) < c_h);
            end else begin
                frame_sync <= 1'b0;
                line_sync  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sft_cmd_shift.sv
module sft_cmd_shift #(
    parameter int CMD_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise_tick,
    input  logic             frame_go,
    input  logic             cmd_load,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             ser_data
);
    localparam int BW = $clog2(CMD_W + 1);

    logic [CMD_W-1:0] pend;
    logic             pend_v;
    logic [CMD_W-1:0] sh;
    logic [BW-1:0]    left;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            pend_v   <= 1'b0;
            sh       <= '0;
            left     <= '0;
            ser_data <= 1'b0;
        end else begin
            if (cmd_load) begin
                pend   <= cmd_word;
                pend_v <= 1'b1;
            end else if (frame_go && pend_v) begin
                pend_v <= 1'b0;
            end

            if (frame_go && pend_v) begin
                sh   <= pend;
                left <= BW'(CMD_W);
            end else if (rise_tick) begin
                if (left != '0) begin
                    ser_data <= sh[CMD_W-1];
                    sh       <= sh << 1;
                    left     <= left - BW'(1);
                end else begin
                    ser_data <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/snap_frame_timer.sv
module snap_frame_timer #(
    parameter int LINE_W = 9,
    parameter int CLKS_W = 10,
    parameter int INT_W  = 16,
    parameter int CMD_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              seq_mode,
    input  logic [INT_W-1:0]  int_clks,
    input  logic [LINE_W-1:0] line_count,
    input  logic [CLKS_W-1:0] line_clks,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              cmd_load,
    output logic              sensor_clk,
    output logic              frame_sync,
    output logic              line_sync,
    output logic              ser_data,
    output logic              busy
);
    logic fall_tick;
    logic rise_tick;
    logic frame_go;

    sft_tick_gen u_tick (
        .clk        (clk),
        .rst        (rst),
        .sensor_clk (sensor_clk),
        .fall_tick  (fall_tick),
        .rise_tick  (rise_tick)
    );

    sft_frame_fsm #(
        .LINE_W (LINE_W),
        .CLKS_W (CLKS_W),
        .INT_W  (INT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .fall_tick  (fall_tick),
        .start      (start),
        .seq_mode   (seq_mode),
        .int_clks   (int_clks),
        .line_count (line_count),
        .line_clks  (line_clks),
        .frame_sync (frame_sync),
        .line_sync  (line_sync),
        .busy       (busy),
        .frame_go   (frame_go)
    );

    sft_cmd_shift #(
        .CMD_W (CMD_W)
    ) u_cmd (
        .clk       (clk),
        .rst       (rst),
        .rise_tick (rise_tick),
        .frame_go  (frame_go),
        .cmd_load  (cmd_load),
        .cmd_word  (cmd_word),
        .ser_data  (ser_data)
    );
endmodule

// File: rtl/sft_checks.sv
module sft_checks (
    input logic clk,
    input logic rst,
    input logic sensor_clk,
    input logic frame_sync,
    input logic line_sync,
    input logic ser_data,
    input logic busy
);
    p_clk_half_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (sensor_clk != $past(sensor_clk)));

    p_data_on_rise_r10: assert property (@(posedge clk) disable iff (rst)
        !$stable(ser_data) |-> $rose(sensor_clk));

    p_sync_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
        (!$stable(frame_sync) || !$stable(line_sync)) |-> $fell(sensor_clk));

    p_line_in_frame_r3: assert property (@(posedge clk) disable iff (rst)
        line_sync |-> busy);

    p_first_line_gap_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_sync) |-> !line_sync);

    p_line_width_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(line_sync) |=> line_sync);

    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(frame_sync) |-> busy);
endmodule

bind snap_frame_timer sft_checks u_chk (
    .clk        (clk),
    .rst        (rst),
    .sensor_clk (sensor_clk),
    .frame_sync (frame_sync),
    .line_sync  (line_sync),
    .ser_data   (ser_data),
    .busy       (busy)
);

// File: tb/tb_snap_frame_timer.sv
module tb_snap_frame_timer;
    localparam int LW = 4;
    localparam int KW = 3;
    localparam int IW = 5;
    localparam int CMDW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          seq_mode = 1'b0;
    logic [IW-1:0] int_clks = '0;
    logic [LW-1:0] line_count = '0;
    logic [KW-1:0] line_clks = '0;
    logic [CMDW-1:0] cmd_word = '0;
    logic          cmd_load = 1'b0;
    logic          sensor_clk, frame_sync, line_sync, ser_data, busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    snap_frame_timer #(.LINE_W(LW), .CLKS_W(KW), .INT_W(IW), .CMD_W(CMDW)) dut (
        .clk(clk), .rst(rst), .start(start), .seq_mode(seq_mode),
        .int_clks(int_clks), .line_count(line_count), .line_clks(line_clks),
        .cmd_word(cmd_word), .cmd_load(cmd_load), .sensor_clk(sensor_clk),
        .frame_sync(frame_sync), .line_sync(line_sync), .ser_data(ser_data),
        .busy(busy)
    );

    task automatic chk(input string req, input string what, input int k,
                       input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s tick %0d: actual=%b expected=%b", req, what, k, got, exp);
        end
    endtask

    // One frame; expected values computed from the requirements.
    task automatic run_frame(input bit md, input int L, input int P, input int I,
                             input bit has_w, input logic [CMDW-1:0] w,
                             input bit load_en, input logic [CMDW-1:0] load_w,
                             input bit poke, input bit scramble,
                             input bit chain_in, input bit chain_out);
        int le, pe, ie, r, h, f, last;
        logic e_fs, e_ls, e_bz, e_sd;
        le = (L == 0) ? 1 : L;
        pe = (P == 0) ? 1 : P;
        ie = (I == 0) ? 1 : I;
        r  = le * pe;
        h  = r + 1 - ((ie < r) ? ie : r);
        f  = md ? (r + ie + 1) : (r + 1);
        last = chain_out ? f - 1 : f;
        if (!chain_in) begin
            @(negedge sensor_clk); #1;
            seq_mode   = md;
            line_count = LW'(L);
            line_clks  = KW'(P);
            int_clks   = IW'(I);
            start      = 1'b1;
        end
        for (int k = 0; k <= last; k++) begin
            @(negedge sensor_clk); #1;
            if (k == 0) start = 1'b0;
            if (k == 0)      e_fs = 1'b1;
            else if (k <= r) e_fs = md ? 1'b1 : (k < h);
            else             e_fs = 1'b0;
            e_ls = (k >= 1) && (k <= r) && (((k - 1) % pe) == 0);
            e_bz = (k < f);
            e_sd = (has_w && k >= 1 && k <= CMDW) ? w[CMDW - k] : 1'b0;
            if (k == 0) chk("R2", "frame_sync at start", k, frame_sync, 1'b1);
            else if (md) chk(scramble ? "R9" : "R4", "frame_sync seq", k, frame_sync, e_fs);
            else         chk(scramble ? "R9" : "R5", "frame_sync ovl", k, frame_sync, e_fs);
            chk(poke ? "R6" : "R3", "line_sync", k, line_sync, e_ls);
            chk(chain_in ? "R7" : "R6", "busy", k, busy, e_bz);
            chk("R8", "ser_data", k, ser_data, e_sd);
            if (scramble && k == 1) begin
                seq_mode   = ~md;
                line_count = line_count + LW'(3);
                line_clks  = line_clks + KW'(2);
                int_clks   = int_clks + IW'(7);
            end
            if (poke && k == 2) start = 1'b1;
            if (poke && k == 3) start = 1'b0;
            if (chain_out && k == f - 1) start = 1'b1;
            if (load_en && k == 2) begin
                cmd_word = load_w;
                cmd_load = 1'b1;
                @(posedge clk); #1;
                cmd_load = 1'b0;
                cmd_word = ~load_w;
            end
        end
    endtask

    task automatic finish_run;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic prev_clk;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state and sensor clock rate
        @(negedge clk);
        chk("R1", "frame_sync reset", 0, frame_sync, 1'b0);
        chk("R1", "line_sync reset", 0, line_sync, 1'b0);
        chk("R1", "ser_data reset", 0, ser_data, 1'b0);
        chk("R1", "busy reset", 0, busy, 1'b0);
        for (int i = 0; i < 4; i++) begin
            prev_clk = sensor_clk;
            @(negedge clk);
            chk("R1", "sensor_clk toggle", i, sensor_clk, ~prev_clk);
        end

        // sweep of small configurations, both modes, zeros included
        for (int md = 0; md < 2; md++)
            for (int li = 0; li < 3; li++)
                for (int pi = 0; pi < 4; pi++)
                    for (int ii = 0; ii < 5; ii++) begin
                        int lv, pv, iv;
                        lv = (li == 0) ? 0 : ((li == 1) ? 1 : 3);
                        pv = (pi == 3) ? 4 : pi;
                        iv = (ii == 0) ? 0 : ((ii == 1) ? 1 : ((ii == 2) ? 2 : ((ii == 3) ? 6 : 15)));
                        run_frame(md[0], lv, pv, iv, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
                    end

        // R6: start requests during a frame are refused
        run_frame(1'b1, 2, 3, 4, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);
        run_frame(1'b0, 3, 2, 2, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0);

        // R9: settings changed mid-frame are ignored
        run_frame(1'b1, 2, 2, 3, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);
        run_frame(1'b0, 3, 3, 4, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R8: a word loaded mid-frame goes out in the next frame
        run_frame(1'b0, 3, 4, 2, 1'b0, '0,     1'b1, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(1'b0, 3, 4, 2, 1'b1, 8'hA5,  1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(1'b1, 2, 3, 5, 1'b1, 8'h3C,  1'b0, '0,    1'b0, 1'b0, 1'b0, 1'b0);
        run_frame(1'b0, 3, 4, 2, 1'b0, '0,     1'b0, '0,    1'b0, 1'b0, 1'b0, 1'b0);

        // R8: latest load while idle wins
        @(negedge sensor_clk); #1;
        cmd_word = 8'h96; cmd_load = 1'b1;
        @(posedge clk); #1;
        cmd_word = 8'h4B;
        @(posedge clk); #1;
        cmd_load = 1'b0; cmd_word = 8'h00;
        run_frame(1'b1, 3, 3, 1, 1'b1, 8'h4B, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R7: back-to-back frames, overlapped then sequential
        run_frame(1'b0, 2, 3, 2, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_frame(1'b0, 2, 3, 2, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
        run_frame(1'b1, 2, 2, 3, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
        run_frame(1'b1, 2, 2, 3, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);

        finish_run();
    end
endmodule